// File: doc/BRIEF.md
# Column-Tree Window SAD Unit

This unit produces a square-window sum of absolute differences (SAD) between a current image and a displaced reference image, one window per accepted column, without any memory whose size grows with the image width. Each cycle it takes a complete vertical column of 2·RAD+1 pixel pairs. A pipelined absolute-difference adder tree reduces that column to a strip sum. A short delay line keeps the last 2·RAD+1 strip sums, and a running horizontal sum adds the newest strip and drops the one that has just left the window.

The column lanes carry the rows y, y−1, …, y−2·RAD. A column flagged as the first of a line clears the running sum and the strip history, so a window never spans two lines. A window is complete once 2·RAD+1 columns of the current line have been accepted. The result then describes the window centred RAD columns and RAD rows behind the newest pixel. Extracting the columns from line storage is left to the logic in front of the unit.

Top module: `csad_window`

## Requirements
- R1: The strip sum of an accepted column is the sum over all 2·RAD+1 lanes of |cur_i − ref_i|. Lane i occupies bits [i·PIX_W +: PIX_W] of `col_cur` and `col_ref`, and lane i carries row y−i.
- R2: For each accepted column, `sad_out` equals the sum of the strip sums of the most recent 2·RAD+1 accepted columns of the current line, this column included. Fewer columns are summed when the line holds fewer.
- R3: An accepted column with `col_first` high starts a new line. No column accepted before it contributes to any later result.
- R4: Exactly one result is produced per accepted column, in order. `sad_valid` rises $clog2(2·RAD+1)+2 rising edges after the edge that accepts the column; with RAD=2 that is 5 edges.
- R5: A cycle with `col_valid` low is ignored. It produces no result, does not move the window, and its `col_first`, `col_cur` and `col_ref` values have no effect.
- R6: While `sad_valid` is high, `win_full` is high if and only if at least 2·RAD+1 columns of the current line have been accepted, this column included.
- R7: While `rst_n` is low and after its release until the first result, `sad_valid`, `win_full` and `sad_out` are 0.
- R8: Results are exact at the largest inputs. A full window of 2·RAD+1 columns, every lane differing by 2^PIX_W−1, gives (2·RAD+1)²·(2^PIX_W−1); that is 6375 for RAD=2 and PIX_W=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| col_valid | input | 1 | A column is presented this cycle |
| col_first | input | 1 | The presented column is the first of a line |
| col_cur | input | (2·RAD+1)·PIX_W | Current-image column, lane i = row y−i |
| col_ref | input | (2·RAD+1)·PIX_W | Displaced reference-image column, same lane order |
| sad_valid | output | 1 | A window result is presented |
| sad_out | output | PIX_W+2·$clog2(2·RAD+1) | Window SAD |
| win_full | output | 1 | The result covers a complete window |

## Verification
The assertions check on every cycle that each pipeline stage's valid follows its input one edge later. They also check that the tree and window sums stay within their arithmetic bounds, that the first column of a line yields exactly its own strip with `win_full` low, and that the window sum holds while no column is accepted. Several things only the bench scenarios can show: the numeric window sum over streams that are steady, broken by bubbles, or restarted, the end-to-end latency count, the fill behaviour of `win_full`, and the exact result at the largest differences. The bench compares them against a model of per-line strip histories.

// File: rtl/csad_pkg.sv
package csad_pkg;

  // Width of a sum of PIX_W-bit terms after `stages` summations over `lanes` terms each.
  function automatic int unsigned sum_width(input int unsigned pix_w,
                                            input int unsigned lanes,
                                            input int unsigned stages);
    return pix_w + stages * $clog2(lanes);
  endfunction

  // Largest value reachable by such a sum.
  function automatic int unsigned sum_bound(input int unsigned pix_w,
                                            input int unsigned lanes,
                                            input int unsigned stages);
    int unsigned b;
    b = (1 << pix_w) - 1;
    for (int unsigned s = 0; s < stages; s++) b = b * lanes;
    return b;
  endfunction

endpackage

// File: rtl/csad_lane_diff.sv
module csad_lane_diff #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_first,
  input  logic [LANES*PIX_W-1:0]       in_cur,
  input  logic [LANES*PIX_W-1:0]       in_ref,
  output logic                         out_valid,
  output logic                         out_first,
  output logic [LANES-1:0][PIX_W-1:0]  out_diff
);

  function automatic logic [PIX_W-1:0] absdiff(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) out_diff[i] <= '0;
      else if (in_valid)
        out_diff[i] <= absdiff(in_cur[i*PIX_W +: PIX_W], in_ref[i*PIX_W +: PIX_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_first <= in_valid & in_first;
    end
  end

  AST_DIFF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R4

endmodule

// File: rtl/csad_tree.sv
module csad_tree #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned LANES = 5,
  parameter int unsigned OUT_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_first,
  input  logic [LANES-1:0][IN_W-1:0]  in_leaf,
  output logic                        out_valid,
  output logic                        out_first,
  output logic [OUT_W-1:0]            out_sum
);

  localparam int unsigned LEVELS = $clog2(LANES);
  localparam int unsigned N2     = 1 << LEVELS;
  localparam int unsigned BOUND  = csad_pkg::sum_bound(IN_W, LANES, 1);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned NODES = N2 >> l;
    logic [OUT_W-1:0] s [NODES];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < NODES; i++) begin : g_n
        if (i < LANES) begin : g_use
          assign s[i] = OUT_W'(in_leaf[i]);
        end else begin : g_pad
          assign s[i] = '0;
        end
      end
    end else begin : g_add
      for (genvar i = 0; i < NODES; i++) begin : g_n
        always_ff @(posedge clk) begin
          if (!rst_n) s[i] <= '0;
          else        s[i] <= g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
        end
      end
    end
  end

  logic [LEVELS-1:0] v_pipe;
  logic [LEVELS-1:0] f_pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_pipe <= '0;
      f_pipe <= '0;
    end else begin
      v_pipe <= {v_pipe[LEVELS-2:0], in_valid};
      f_pipe <= {f_pipe[LEVELS-2:0], in_valid & in_first};
    end
  end

  assign out_valid = v_pipe[LEVELS-1];
  assign out_first = f_pipe[LEVELS-1];
  assign out_sum   = g_lvl[LEVELS].s[0];

  AST_TREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    v_pipe[0] == $past(in_valid)); // R4
  AST_TREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_sum) <= BOUND)); // R8

endmodule

// File: rtl/csad_hsum.sv
module csad_hsum #(
  parameter int unsigned LANES   = 5,
  parameter int unsigned STRIP_W = 11,
  parameter int unsigned SAD_W   = 14,
  parameter int unsigned BOUND   = 6375
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_first,
  input  logic [STRIP_W-1:0] in_strip,
  output logic               out_valid,
  output logic               out_full,
  output logic [SAD_W-1:0]   out_sum
);

  localparam int unsigned CNT_W = $clog2(LANES + 1);

  logic [STRIP_W-1:0] dly [LANES];
  logic [SAD_W-1:0]   win_q;
  logic [CNT_W-1:0]   cnt_q;

  // Named internal events used by the datapath and the checks.
  logic [SAD_W-1:0]   win_base;
  logic [STRIP_W-1:0] strip_drop;
  logic [SAD_W-1:0]   win_nx;
  logic [CNT_W-1:0]   cnt_nx;
  logic               full_nx;

  always_comb begin
    win_base   = in_first ? '0 : win_q;
    strip_drop = in_first ? '0 : dly[LANES-1];
    win_nx     = win_base + SAD_W'(in_strip) - SAD_W'(strip_drop);
    if (in_first)                        cnt_nx = CNT_W'(1);
    else if (cnt_q == CNT_W'(LANES))     cnt_nx = cnt_q;
    else                                 cnt_nx = cnt_q + CNT_W'(1);
    full_nx = (cnt_nx == CNT_W'(LANES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LANES; k++) dly[k] <= '0;
      win_q     <= '0;
      cnt_q     <= '0;
      out_full  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dly[0] <= in_strip;
        for (int k = 1; k < LANES; k++) dly[k] <= in_first ? '0 : dly[k-1];
        win_q    <= win_nx;
        cnt_q    <= cnt_nx;
        out_full <= full_nx;
      end
    end
  end

  assign out_sum = win_q;

  AST_SUM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_sum) <= BOUND)); // R8
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_first)) |-> (out_sum == SAD_W'($past(in_strip)))); // R3
  AST_FIRST_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_first)) |-> !out_full); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sum)); // R5

endmodule

// File: rtl/csad_window.sv
module csad_window #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned RAD   = 2,
  localparam int unsigned LANES   = 2 * RAD + 1,
  localparam int unsigned STRIP_W = csad_pkg::sum_width(PIX_W, LANES, 1),
  localparam int unsigned SAD_W   = csad_pkg::sum_width(PIX_W, LANES, 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   col_valid,
  input  logic                   col_first,
  input  logic [LANES*PIX_W-1:0] col_cur,
  input  logic [LANES*PIX_W-1:0] col_ref,
  output logic                   sad_valid,
  output logic [SAD_W-1:0]       sad_out,
  output logic                   win_full
);

  localparam int unsigned WIN_BOUND = csad_pkg::sum_bound(PIX_W, LANES, 2);

  logic                        d_valid;
  logic                        d_first;
  logic [LANES-1:0][PIX_W-1:0] d_diff;
  logic                        t_valid;
  logic                        t_first;
  logic [STRIP_W-1:0]          t_strip;

  csad_lane_diff #(.PIX_W(PIX_W), .LANES(LANES)) u_diff (
    .clk(clk), .rst_n(rst_n),
    .in_valid(col_valid), .in_first(col_first),
    .in_cur(col_cur), .in_ref(col_ref),
    .out_valid(d_valid), .out_first(d_first), .out_diff(d_diff)
  );

  csad_tree #(.IN_W(PIX_W), .LANES(LANES), .OUT_W(STRIP_W)) u_tree (
    .clk(clk), .rst_n(rst_n),
    .in_valid(d_valid), .in_first(d_first), .in_leaf(d_diff),
    .out_valid(t_valid), .out_first(t_first), .out_sum(t_strip)
  );

  csad_hsum #(.LANES(LANES), .STRIP_W(STRIP_W), .SAD_W(SAD_W), .BOUND(WIN_BOUND)) u_hsum (
    .clk(clk), .rst_n(rst_n),
    .in_valid(t_valid), .in_first(t_first), .in_strip(t_strip),
    .out_valid(sad_valid), .out_full(win_full), .out_sum(sad_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sad_valid && !win_full && sad_out == '0)); // R7

endmodule

// File: tb/csad_window_tb_top.sv
module csad_window_tb_top;

  localparam int PIX_W = 8;
  localparam int RAD   = 2;
  localparam int LANES = 2 * RAD + 1;
  localparam int LAT   = $clog2(LANES) + 2;
  localparam int SAD_W = PIX_W + 2 * $clog2(LANES);
  localparam int DEPTH = 512;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   col_valid = 1'b0;
  logic                   col_first = 1'b0;
  logic [LANES*PIX_W-1:0] col_cur = '0;
  logic [LANES*PIX_W-1:0] col_ref = '0;
  logic                   sad_valid;
  logic [SAD_W-1:0]       sad_out;
  logic                   win_full;

  always #10 clk = ~clk;

  csad_window #(.PIX_W(PIX_W), .RAD(RAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .col_first(col_first),
    .col_cur(col_cur), .col_ref(col_ref),
    .sad_valid(sad_valid), .sad_out(sad_out), .win_full(win_full)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  int    exp_sad  [DEPTH];
  bit    exp_full [DEPTH];
  string exp_req  [DEPTH];
  int    wr_n = 0;
  int    rd_n = 0;
  int    hist [LANES];
  int    line_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int strip_of(input logic [LANES*PIX_W-1:0] a,
                                  input logic [LANES*PIX_W-1:0] b);
    int s = 0;
    for (int i = 0; i < LANES; i++) begin
      int x = int'(a[i*PIX_W +: PIX_W]);
      int y = int'(b[i*PIX_W +: PIX_W]);
      s += (x > y) ? x - y : y - x;
    end
    return s;
  endfunction

  function automatic logic [LANES*PIX_W-1:0] pat(input int seed, input int mul);
    logic [LANES*PIX_W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*PIX_W +: PIX_W] = PIX_W'((seed * mul + i * 53 + 17) % 256);
    return v;
  endfunction

  // Results are compared as they appear.
  always @(negedge clk) begin
    if (rst_n && sad_valid && !done) begin
      if (rd_n >= wr_n) begin
        chk(1'b0, "R4", "unexpected result", int'(sad_out), -1);
      end else begin
        chk(int'(sad_out) == exp_sad[rd_n % DEPTH], exp_req[rd_n % DEPTH], "sad_out",
            int'(sad_out), exp_sad[rd_n % DEPTH]);
        chk(win_full == exp_full[rd_n % DEPTH], "R6", "win_full",
            int'(win_full), int'(exp_full[rd_n % DEPTH]));
        rd_n++;
      end
    end
  end

  task automatic send_col(input logic [LANES*PIX_W-1:0] a, input logic [LANES*PIX_W-1:0] b,
                          input bit first, input string req);
    int sum = 0;
    col_cur = a; col_ref = b; col_first = first; col_valid = 1'b1;
    if (first) begin
      for (int k = 0; k < LANES; k++) hist[k] = 0;
      line_cnt = 0;
    end
    for (int k = LANES - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = strip_of(a, b);
    if (line_cnt < LANES) line_cnt++;
    for (int k = 0; k < LANES; k++) sum += hist[k];
    exp_sad[wr_n % DEPTH]  = sum;
    exp_full[wr_n % DEPTH] = (line_cnt >= LANES);
    exp_req[wr_n % DEPTH]  = req;
    wr_n++;
    @(negedge clk);
  endtask

  // Idle cycles carry junk that must be ignored (R5).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      col_valid = 1'b0;
      col_first = 1'b1;
      col_cur   = pat(i + 99, 13);
      col_ref   = pat(i + 7, 201);
      @(negedge clk);
    end
    col_first = 1'b0;
  endtask

  task automatic drain(input string req);
    int w = 0;
    col_valid = 1'b0;
    while (rd_n != wr_n && w < 40) begin
      @(negedge clk);
      w++;
    end
    chk(rd_n == wr_n, req, "results outstanding", rd_n, wr_n);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(sad_valid == 1'b0, "R7", "sad_valid in reset", int'(sad_valid), 0);
    chk(win_full == 1'b0, "R7", "win_full in reset", int'(win_full), 0);
    chk(sad_out == '0, "R7", "sad_out in reset", int'(sad_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sad_valid == 1'b0 && sad_out == '0, "R7", "quiet after release", int'(sad_out), 0);
  endtask

  task automatic t_latency();
    int first_hi = -1;
    send_col(pat(3, 31), pat(5, 77), 1'b1, "R1");
    col_valid = 1'b0;
    for (int k = 1; k <= LAT + 2; k++) begin
      if (sad_valid && first_hi < 0) first_hi = k;
      if (k < LAT + 2) @(negedge clk);
    end
    chk(first_hi == LAT, "R4", "latency in edges", first_hi, LAT);
    drain("R4");
  endtask

  task automatic t_stream();
    for (int c = 0; c < 12; c++) send_col(pat(c + 1, 29), pat(c + 4, 91), c == 0, "R2");
    drain("R2");
  endtask

  task automatic t_bubbles();
    for (int c = 0; c < 10; c++) begin
      send_col(pat(c + 40, 57), pat(c + 2, 23), c == 0, "R5");
      if (c % 3 == 1) idle(c % 4 + 1);
    end
    drain("R5");
  endtask

  task automatic t_restart();
    for (int c = 0; c < 8; c++) send_col(pat(c + 60, 19), pat(c, 211), c == 0, "R3");
    for (int c = 0; c < 7; c++) send_col(pat(c + 80, 33), pat(c + 9, 5), c == 0, "R3");
    send_col(pat(1, 1), pat(2, 2), 1'b1, "R3");
    send_col(pat(4, 3), pat(6, 9), 1'b1, "R3");
    drain("R3");
  endtask

  task automatic t_max();
    logic [LANES*PIX_W-1:0] ones;
    ones = '1;
    for (int c = 0; c < 7; c++) send_col(c[0] ? ones : '0, c[0] ? '0 : ones, c == 0, "R8");
    drain("R8");
    chk(exp_sad[(wr_n - 1) % DEPTH] == LANES * LANES * 255, "R8", "model full-scale",
        exp_sad[(wr_n - 1) % DEPTH], LANES * LANES * 255);
  endtask

  task automatic t_zero();
    for (int c = 0; c < 6; c++) send_col(pat(c + 5, 41), pat(c + 5, 41), c == 0, "R1");
    drain("R1");
    chk(sad_out == '0, "R1", "equal columns give zero", int'(sad_out), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_latency();
    t_stream();
    t_bubbles();
    t_restart();
    t_max();
    t_zero();
    idle(10);
    chk(rd_n == wr_n, "R4", "one result per column", rd_n, wr_n);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", rd_n, wr_n);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule